// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for every received frame, whether the MAC should keep it, judging only by the 48-bit destination address. It offers three ways to accept a frame: a promiscuous switch that lets everything through, a small table of exact station addresses, and a 64-bin multicast hash keyed by a CRC-32 value that an upstream engine has already computed over the six address bytes. The block also compares the frame length with a programmable limit and flags frames that are too long.

Software programs the filter through a simple 16-bit write port. The writable items are the control bits, the per-entry enable mask, the length limit, four hash words and three 16-bit halves per exact entry. Each lookup is presented as a one-cycle strobe with address, CRC and length. The verdict comes back one clock later as an accept bit, a reason code and the too-long flag.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the promiscuous and hash-enable bits are clear, only exact entry 0 is enabled, entry 0 holds all-ones, the other entries hold zero, the length limit equals MAX_LEN (9600), and `dec_valid` is low.
- R2: Each cycle with `rx_valid` high produces exactly one cycle with `dec_valid` high on the following clock. Cycles without `rx_valid` produce no verdict, and back-to-back lookups produce back-to-back verdicts in order.
- R3: When the promiscuous bit (bit 0 of the control word at address 0x00) is set, every frame is accepted with reason 1.
- R4: The destination address carries byte k, with byte 0 first on the wire, in `rx_da[8k+7:8k]`. Exact entry i is written at address 0x10+4i (bytes 1:0), 0x11+4i (bytes 3:2) and 0x12+4i (bytes 5:4). A frame whose address equals an enabled entry is accepted with reason 2.
- R5: The enable mask is written at address 0x01, with bit i enabling entry i. An entry whose enable bit is clear never matches.
- R6: A write to an entry's address halves is discarded while that entry's enable bit is set.
- R7: With hash enable (bit 1 of the control word) set, a multicast frame (bit 0 of byte 0 set) whose bin is set is accepted with reason 3. The bin is `rx_crc[28:23]`. The four hash words sit at addresses 0x04..0x07, bin bits 5:4 select the word and bits 3:0 select the bit within it. Unicast frames never take the hash path.
- R8: With hash enable clear, the hash words have no effect on the verdict.
- R9: Writing 0xFFFF to all four hash words with hash enable set accepts every multicast address.
- R10: Reason priority is promiscuous (1), then exact (2), then hash (3). A dropped frame reports reason 0, and `dec_accept` is high exactly when the reason is not 0.
- R11: `dec_too_long` is set when `rx_len` exceeds the limit written at address 0x02. A written limit above MAX_LEN is stored as MAX_LEN.
- R12: With the reset configuration, the broadcast address is accepted with reason 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| rx_valid | input | 1 | Lookup strobe |
| rx_da | input | 48 | Destination address, byte k in bits 8k+7:8k |
| rx_crc | input | 32 | CRC-32 of the six address bytes |
| rx_len | input | LEN_W (14) | Frame length in bytes, header and FCS included |
| dec_valid | output | 1 | Verdict strobe, one cycle after `rx_valid` |
| dec_accept | output | 1 | Frame is accepted |
| dec_reason | output | 2 | 0 drop, 1 promiscuous, 2 exact, 3 hash |
| dec_too_long | output | 1 | Length exceeds the programmed limit |

## Verification
The bench builds the block with its default parameters: four exact entries, a 14-bit length field and a 9600-byte ceiling. Four entries are enough to reach the reset-loaded entry 0, a middle entry and the last entry (index 3). The bench uses the last entry to put exact and hash hits on the same multicast address and so check priority. The 9600 ceiling lets the bench probe the limit on both sides and write a value above it to exercise the clamp.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int CFG_AW     = 8;
    localparam int HALF_W     = 16;
    localparam int DA_W       = 48;
    localparam int CRC_W      = 32;
    localparam int HASH_BITS  = 64;
    localparam int HASH_WORDS = HASH_BITS / HALF_W;
    localparam int BIN_W      = 6;
    localparam int BIN_LSB    = 23;
    localparam int HALVES     = DA_W / HALF_W;

    // configuration word addresses
    localparam logic [CFG_AW-1:0] A_CTRL   = 8'h00;
    localparam logic [CFG_AW-1:0] A_ENMASK = 8'h01;
    localparam logic [CFG_AW-1:0] A_LENLIM = 8'h02;
    localparam logic [CFG_AW-1:0] A_HASH0  = 8'h04;
    localparam logic [CFG_AW-1:0] A_ENTRY0 = 8'h10;

    // control word bit positions
    localparam int CB_PROMISC = 0;
    localparam int CB_HASHEN  = 1;

    typedef enum logic [1:0] {
        RSN_DROP    = 2'd0,
        RSN_PROMISC = 2'd1,
        RSN_EXACT   = 2'd2,
        RSN_HASH    = 2'd3
    } reason_e;

    typedef struct packed {
        logic    accept;
        reason_e reason;
        logic    too_long;
    } verdict_t;

    function automatic logic [BIN_W-1:0] hash_bin(input logic [CRC_W-1:0] crc);
        return crc[BIN_LSB +: BIN_W];
    endfunction

endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
    import rxaf_pkg::*;
#(
    parameter int N_EXACT = 4,
    parameter int LEN_W   = 14,
    parameter int MAX_LEN = 9600
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cfg_we,
    input  logic [CFG_AW-1:0]               cfg_addr,
    input  logic [HALF_W-1:0]               cfg_wdata,
    output logic                            promisc,
    output logic                            hash_en,
    output logic [N_EXACT-1:0]              ex_en,
    output logic [N_EXACT-1:0][DA_W-1:0]    ex_addr,
    output logic [HASH_BITS-1:0]            hash_tbl,
    output logic [LEN_W-1:0]                max_len
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] len_wr;
    assign len_wr = cfg_wdata[LEN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            promisc <= 1'b0;
            hash_en <= 1'b0;
            ex_en   <= N_EXACT'(1);
            max_len <= LEN_CAP;
        end else if (cfg_we) begin
            if (cfg_addr == A_CTRL) begin
                promisc <= cfg_wdata[CB_PROMISC];
                hash_en <= cfg_wdata[CB_HASHEN];
            end
            if (cfg_addr == A_ENMASK) ex_en <= cfg_wdata[N_EXACT-1:0];
            if (cfg_addr == A_LENLIM) max_len <= (len_wr > LEN_CAP) ? LEN_CAP : len_wr;
        end
    end

    logic [HASH_WORDS-1:0][HALF_W-1:0] hash_words;
    always_ff @(posedge clk) begin
        if (rst) begin
            hash_words <= '0;
        end else if (cfg_we) begin
            for (int w = 0; w < HASH_WORDS; w++) begin
                if (cfg_addr == A_HASH0 + CFG_AW'(w)) hash_words[w] <= cfg_wdata;
            end
        end
    end
    assign hash_tbl = hash_words;

    for (genvar i = 0; i < N_EXACT; i++) begin : g_entry
        localparam logic [CFG_AW-1:0] BASE = A_ENTRY0 + CFG_AW'(4 * i);
        logic [HALVES-1:0][HALF_W-1:0] halves;

        always_ff @(posedge clk) begin
            if (rst) begin
                halves <= (i == 0) ? '1 : '0;
            end else if (cfg_we && !ex_en[i]) begin
                for (int h = 0; h < HALVES; h++) begin
                    if (cfg_addr == BASE + CFG_AW'(h)) halves[h] <= cfg_wdata;
                end
            end
        end
        assign ex_addr[i] = halves;

        // R6: a live entry keeps its address whatever is written to it
        p_locked_entry_r6: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && ex_en[i] && cfg_addr[CFG_AW-1:2] == BASE[CFG_AW-1:2])
            |=> $stable(ex_addr[i]));
    end

    // R11: the stored limit never exceeds the ceiling
    p_len_cap_r11: assert property (@(posedge clk) disable iff (rst) max_len <= LEN_CAP);

endmodule

// File: rtl/rxaf_exact.sv
module rxaf_exact
    import rxaf_pkg::*;
#(
    parameter int N_EXACT = 4
) (
    input  logic [DA_W-1:0]               da,
    input  logic [N_EXACT-1:0]            ex_en,
    input  logic [N_EXACT-1:0][DA_W-1:0]  ex_addr,
    output logic                          hit
);

    logic [N_EXACT-1:0] match;

    for (genvar i = 0; i < N_EXACT; i++) begin : g_cmp
        assign match[i] = ex_en[i] && (ex_addr[i] == da);
    end

    assign hit = |match;

endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
    import rxaf_pkg::*;
(
    input  logic [DA_W-1:0]      da,
    input  logic [CRC_W-1:0]     crc,
    input  logic [HASH_BITS-1:0] hash_tbl,
    input  logic                 hash_en,
    output logic                 hit
);

    logic [HASH_WORDS-1:0][HALF_W-1:0] words;
    logic [BIN_W-1:0]                  bin;
    logic [HALF_W-1:0]                 sel_word;
    logic                              is_mcast;

    assign words    = hash_tbl;
    assign bin      = hash_bin(crc);
    assign sel_word = words[bin[BIN_W-1:4]];
    assign is_mcast = da[0];
    assign hit      = hash_en && is_mcast && sel_word[bin[3:0]];

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int N_EXACT = 4,
    parameter int LEN_W   = 14,
    parameter int MAX_LEN = 9600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              rx_valid,
    input  logic [47:0]       rx_da,
    input  logic [31:0]       rx_crc,
    input  logic [LEN_W-1:0]  rx_len,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [1:0]        dec_reason,
    output logic              dec_too_long
);

    logic                           promisc;
    logic                           hash_en;
    logic [N_EXACT-1:0]             ex_en;
    logic [N_EXACT-1:0][DA_W-1:0]   ex_addr;
    logic [HASH_BITS-1:0]           hash_tbl;
    logic [LEN_W-1:0]               max_len;
    logic                           exact_hit;
    logic                           hash_hit;

    rxaf_regs #(.N_EXACT(N_EXACT), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .promisc  (promisc),
        .hash_en  (hash_en),
        .ex_en    (ex_en),
        .ex_addr  (ex_addr),
        .hash_tbl (hash_tbl),
        .max_len  (max_len)
    );

    rxaf_exact #(.N_EXACT(N_EXACT)) u_exact (
        .da     (rx_da),
        .ex_en  (ex_en),
        .ex_addr(ex_addr),
        .hit    (exact_hit)
    );

    rxaf_hash u_hash (
        .da      (rx_da),
        .crc     (rx_crc),
        .hash_tbl(hash_tbl),
        .hash_en (hash_en),
        .hit     (hash_hit)
    );

    verdict_t v_nxt, v_q;

    always_comb begin
        v_nxt = '0;
        if (promisc)        v_nxt.reason = RSN_PROMISC;
        else if (exact_hit) v_nxt.reason = RSN_EXACT;
        else if (hash_hit)  v_nxt.reason = RSN_HASH;
        else                v_nxt.reason = RSN_DROP;
        v_nxt.accept   = (v_nxt.reason != RSN_DROP);
        v_nxt.too_long = (rx_len > max_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            v_q       <= '0;
        end else begin
            dec_valid <= rx_valid;
            if (rx_valid) v_q <= v_nxt;
        end
    end

    assign dec_accept   = v_q.accept;
    assign dec_reason   = v_q.reason;
    assign dec_too_long = v_q.too_long;

    // R2: one verdict per lookup, on the next clock
    p_verdict_follows_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> dec_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !dec_valid);

    // R3: promiscuous mode accepts everything
    p_promisc_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && promisc) |=> (dec_accept && dec_reason == 2'(RSN_PROMISC)));

    // R10: an exact hit outranks the hash path
    p_exact_first_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !promisc && exact_hit) |=> (dec_reason == 2'(RSN_EXACT)));

    // R8: with hashing off and no other hit, the frame is dropped
    p_hash_off_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !promisc && !exact_hit && !hash_en) |=> !dec_accept);

    // R11: length flag tracks the limit in force at lookup time
    p_too_long_r11: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> (dec_too_long == ($past(rx_len) > $past(max_len))));

    // R10: accept and reason agree
    always_comb begin
        if (!rst && dec_valid) begin
            p_accept_reason_r10: assert (dec_accept == (dec_reason != 2'(RSN_DROP)));
        end
    end

endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;

    localparam int CLK_PERIOD = 10;
    localparam int NE         = 4;
    localparam int LW         = 14;
    localparam int CEIL       = 9600;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          rx_valid = 1'b0;
    logic [47:0]   rx_da = '0;
    logic [31:0]   rx_crc = '0;
    logic [LW-1:0] rx_len = '0;
    logic          dec_valid;
    logic          dec_accept;
    logic [1:0]    dec_reason;
    logic          dec_too_long;

    rx_addr_filter #(.N_EXACT(NE), .LEN_W(LW), .MAX_LEN(CEIL)) dut (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata,
        .rx_valid, .rx_da, .rx_crc, .rx_len,
        .dec_valid, .dec_accept, .dec_reason, .dec_too_long
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    // mirror of the programmed state, kept from the writes the bench issues
    logic           m_prom;
    logic           m_hen;
    logic [NE-1:0]  m_en;
    logic [47:0]    m_ent [NE];
    logic [63:0]    m_hash;
    int             m_max;

    // scoreboard: {accept, reason[1:0], too_long}
    logic [3:0] exp_q [$];
    string      tag_q [$];

    function automatic logic [47:0] mk_da(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    function automatic logic [31:0] crc_bin(input int bin);
        return 32'(bin) << 23;
    endfunction

    function automatic logic [3:0] predict(input logic [47:0] da, input logic [31:0] crc, input int len);
        logic [1:0] rsn;
        logic ex = 1'b0;
        int bin = int'(crc[28:23]);
        for (int i = 0; i < NE; i++) if (m_en[i] && m_ent[i] == da) ex = 1'b1;
        if (m_prom)                             rsn = 2'd1;
        else if (ex)                            rsn = 2'd2;
        else if (m_hen && da[0] && m_hash[bin]) rsn = 2'd3;
        else                                    rsn = 2'd0;
        return {rsn != 2'd0, rsn, len > m_max};
    endfunction

    task automatic cfg_wr(input logic [7:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 8'h00) begin m_prom = d[0]; m_hen = d[1]; end
        else if (a == 8'h01) m_en = d[NE-1:0];
        else if (a == 8'h02) m_max = (int'(d[LW-1:0]) > CEIL) ? CEIL : int'(d[LW-1:0]);
        else if (a >= 8'h04 && a <= 8'h07) m_hash[(int'(a) - 4) * 16 +: 16] = d;
        else if (a >= 8'h10 && int'(a) < 16 + 4 * NE) begin
            int i = (int'(a) - 16) / 4;
            int h = (int'(a) - 16) % 4;
            if (h < 3 && !m_en[i]) m_ent[i][h * 16 +: 16] = d;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_entry(input int i, input logic [47:0] da);
        for (int h = 0; h < 3; h++) cfg_wr(8'(16 + 4 * i + h), da[h * 16 +: 16]);
    endtask

    task automatic send(input logic [47:0] da, input logic [31:0] crc, input int len, input string tag);
        rx_valid = 1'b1; rx_da = da; rx_crc = crc; rx_len = LW'(len);
        exp_q.push_back(predict(da, crc, len));
        tag_q.push_back(tag);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R2 missing verdicts: actual=%0d pending expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            logic [3:0] act;
            act = {dec_accept, dec_reason, dec_too_long};
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2 verdict with no lookup: actual=%h expected=none", act);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== e) begin
                    failures++;
                    $display("FAIL %s {accept,reason,too_long}: actual=%b expected=%b", t, act, e);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    logic [47:0] bcast, sta, sta_sw, sta2, mc1, mc2, uni;

    initial begin
        m_prom = 0; m_hen = 0; m_en = NE'(1); m_hash = '0; m_max = CEIL;
        for (int i = 0; i < NE; i++) m_ent[i] = (i == 0) ? '1 : '0;
        bcast  = '1;
        sta    = mk_da(8'h00, 8'h07, 8'h43, 8'h00, 8'h13, 8'h09);
        sta_sw = mk_da(8'h07, 8'h00, 8'h00, 8'h43, 8'h09, 8'h13);
        sta2   = mk_da(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        mc1    = mk_da(8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'h01);
        mc2    = mk_da(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'hfb);
        uni    = mk_da(8'h00, 8'h1b, 8'h21, 8'haa, 8'hbb, 8'hcc);

        repeat (3) @(negedge clk);
        checks++;
        if (dec_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 dec_valid in reset: actual=%b expected=0", dec_valid);
        end
        rst = 1'b0;
        @(negedge clk);

        // reset configuration: broadcast via entry 0, others dropped
        send(bcast, crc_bin(5), 64, "R12");
        send(sta, crc_bin(42), 64, "R1");
        send(mc1, crc_bin(42), 64, "R1");
        drain();

        // program entry 1 while disabled; disabled entry does not match
        set_entry(1, sta);
        send(sta, crc_bin(7), 100, "R5");
        cfg_wr(8'h01, 16'h0003);
        send(sta, crc_bin(7), 100, "R4");
        send(sta_sw, crc_bin(7), 100, "R4");
        drain();

        // writes to a live entry are discarded
        set_entry(1, sta2);
        send(sta, crc_bin(9), 100, "R6");
        send(sta2, crc_bin(9), 100, "R6");
        drain();

        // disabling entry 0 removes broadcast acceptance
        cfg_wr(8'h01, 16'h0002);
        send(bcast, crc_bin(5), 64, "R5");
        drain();

        // hash: bin 42 -> word 2, bit 10
        cfg_wr(8'h06, 16'h0400);
        send(mc1, crc_bin(42), 64, "R8");
        cfg_wr(8'h00, 16'h0002);
        send(mc1, crc_bin(42), 64, "R7");
        send(mc1, crc_bin(43), 64, "R7");
        send(uni, crc_bin(42), 64, "R7");
        send(mc2, crc_bin(10), 64, "R7");
        cfg_wr(8'h04, 16'h0001);
        send(mc2, crc_bin(0), 64, "R7");
        send(mc2, crc_bin(63), 64, "R7");
        drain();

        // all-ones table
        for (int w = 0; w < 4; w++) cfg_wr(8'(4 + w), 16'hffff);
        send(mc1, crc_bin(0), 64, "R9");
        send(mc2, crc_bin(31), 64, "R9");
        send(bcast, crc_bin(63), 64, "R9");
        send(uni, crc_bin(17), 64, "R9");
        cfg_wr(8'h00, 16'h0000);
        send(mc2, crc_bin(31), 64, "R8");
        drain();

        // priority: entry 3 holds a multicast address also in the hash
        cfg_wr(8'h01, 16'h0002);
        set_entry(3, mc1);
        cfg_wr(8'h01, 16'h000a);
        cfg_wr(8'h00, 16'h0002);
        send(mc1, crc_bin(3), 64, "R10");
        send(mc2, crc_bin(3), 64, "R10");
        cfg_wr(8'h00, 16'h0003);
        send(mc1, crc_bin(3), 64, "R10");
        send(uni, crc_bin(3), 64, "R3");
        send(sta_sw, crc_bin(50), 64, "R3");
        cfg_wr(8'h00, 16'h0000);
        send(uni, crc_bin(3), 64, "R10");
        drain();

        // length limit
        send(sta, crc_bin(1), 9600, "R11");
        send(sta, crc_bin(1), 9601, "R11");
        cfg_wr(8'h02, 16'd1518);
        send(sta, crc_bin(1), 1518, "R11");
        send(sta, crc_bin(1), 1519, "R11");
        cfg_wr(8'h02, 16'd12000);
        send(sta, crc_bin(1), 9600, "R11");
        send(sta, crc_bin(1), 9601, "R11");
        drain();

        // idle: no verdict without a lookup
        checks++;
        if (dec_valid !== 1'b0) begin
            failures++;
            $display("FAIL R2 dec_valid while idle: actual=%b expected=0", dec_valid);
        end

        done = 1;
        finish_run();
    end

endmodule